// File: doc/BRIEF.md
# Two's-Complement Add/Subtract Unit with Condition Flags

This block is a purely combinational arithmetic unit that either adds or subtracts two 8-bit operands. A single mode input selects the operation. Both operations share one ripple-carry chain built from full-adder cells. In subtract mode, every bit of the second operand is inverted before it reaches the chain, and the carry into bit 0 is forced high. Together these form the two's complement of that operand, so the same adder produces the difference.

Along with the result, the unit produces six condition flags taken from the carry chain and the result word: carry/borrow, parity, half-carry out of the low nibble, zero, sign and signed overflow. It is meant to sit in a datapath where a register stage elsewhere captures the result and the flags. It holds no state of its own.

Top module: `addsub_flags`

## Requirements
- R1: With sub_mode = 0, result equals (a_in + b_in) modulo 256.
- R2: With sub_mode = 1, result equals (a_in - b_in) modulo 256, with both operands read as two's-complement numbers.
- R3: flags[0] is the carry flag. In add mode it is the carry out of bit 7. In subtract mode it is 1 exactly when a_in < b_in as unsigned numbers, which is a borrow.
- R4: flags[1] is the parity flag. It is 1 when the 8-bit result contains an even number of one bits.
- R5: flags[2] is the half-carry flag. In add mode it is 1 when a_in[3:0] + b_in[3:0] > 15. In subtract mode it is 1 when a_in[3:0] < b_in[3:0].
- R6: flags[3] is the zero flag. It is 1 exactly when every result bit is 0.
- R7: flags[4] is the sign flag and equals result[7].
- R8: flags[5] is the signed overflow flag. It is 1 when the true signed sum or difference lies outside -128..127. This is the XOR of the carry into bit 7 and the carry out of bit 7.
- R9: The unit has no clock and no storage. result and flags depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | First operand (minuend when subtracting) |
| b_in | input | 8 | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 8 | Sum or difference, modulo 256 |
| flags | output | 6 | {overflow, sign, zero, half-carry, parity, carry} from bit 5 down to bit 0 |

## Verification
No register sits between the inputs and the outputs, so the result and all six flags are due in the same time step as the operand change, zero clock cycles later. The bench drives each operand pair and mode away from any clock edge. It waits one nanosecond for the combinational logic to settle, then compares against values it computes with plain integer arithmetic. Both modes are swept over every one of the 65,536 operand pairs, and directed cases first cover the overflow, borrow, half-carry and zero boundaries.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned PARITY_W = 8;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic hcy;
    logic par;
    logic cry;
  } cond_flags_t;

  localparam int unsigned FLAG_W = $bits(cond_flags_t);
endpackage

// File: rtl/operand_gate.sv
module operand_gate #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opnd_i,
  input  logic         invert_i,
  output logic [W-1:0] opnd_o
);
  // conditional inversion, one XOR per bit
  for (genvar k = 0; k < W; k++) begin : g_inv
    assign opnd_o[k] = opnd_i[k] ^ invert_i;
  end

  always_comb begin
    // R2
    inv_gate_chk: assert (invert_i ? (opnd_o == ~opnd_i) : (opnd_o == opnd_i));
  end
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  logic half;
  assign half   = x_i ^ y_i;
  assign sum_o  = half ^ cin_i;
  assign cout_o = (x_i & y_i) | (half & cin_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W:0]   cy_o
);
  assign cy_o[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_cell
    fa_cell u_fa (
      .x_i    (x_i[k]),
      .y_i    (y_i[k]),
      .cin_i  (cy_o[k]),
      .sum_o  (sum_o[k]),
      .cout_o (cy_o[k+1])
    );
  end

  logic [W:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
    // R1
    chain_sum_chk: assert ({cy_o[W], sum_o} == ref_sum);
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import addsub_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned NIB   = NIB_W,
  parameter int unsigned PAR_N = PARITY_W
) (
  input  logic [W-1:0] res_i,
  input  logic [W:0]   cy_i,
  input  logic         sub_i,
  output cond_flags_t  flg_o
);
  localparam int unsigned PW = (W < PAR_N) ? W : PAR_N;

  always_comb begin
    flg_o     = '0;
    flg_o.cry = cy_i[W] ^ sub_i;
    flg_o.par = ~(^res_i[PW-1:0]);
    flg_o.hcy = cy_i[NIB] ^ sub_i;
    flg_o.zro = ~(|res_i);
    flg_o.sgn = res_i[W-1];
    flg_o.ovf = cy_i[W-1] ^ cy_i[W];
  end

  always_comb begin
    // R6
    zero_flag_chk: assert (!flg_o.zro || (res_i == '0));
    // R4
    parity_flag_chk: assert (flg_o.par == ($countones(res_i[PW-1:0]) % 2 == 0));
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic              sub_mode,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags
);
  logic [W-1:0] b_eff;
  logic [W:0]   cy;
  cond_flags_t  flg;

  operand_gate #(.W(W)) u_gate (
    .opnd_i   (b_in),
    .invert_i (sub_mode),
    .opnd_o   (b_eff)
  );

  ripple_chain #(.W(W)) u_chain (
    .x_i   (a_in),
    .y_i   (b_eff),
    .cin_i (sub_mode),
    .sum_o (result),
    .cy_o  (cy)
  );

  flag_gen #(.W(W)) u_flags (
    .res_i (result),
    .cy_i  (cy),
    .sub_i (sub_mode),
    .flg_o (flg)
  );

  assign flags = flg;

  logic [W:0] wide_add;
  logic       sa, sb, sr;
  always_comb begin
    wide_add = {1'b0, a_in} + {1'b0, b_in};
    sa = a_in[W-1];
    sb = b_in[W-1];
    sr = result[W-1];
    // R1
    add_result_chk: assert (sub_mode || (result == wide_add[W-1:0]));
    // R2
    sub_result_chk: assert (!sub_mode || (result == W'(a_in - b_in)));
    // R3
    carry_borrow_chk: assert (sub_mode ? (flg.cry == (a_in < b_in)) : (flg.cry == wide_add[W]));
    // R8
    ovf_sign_chk: assert (flg.ovf == (sub_mode ? ((sa != sb) && (sr != sa))
                                               : ((sa == sb) && (sr != sa))));
    // R7
    sign_out_chk: assert (flags[4] == result[W-1]);
  end
endmodule

// File: tb/sim_addsub_flags.sv
`timescale 1ns/1ps
module sim_addsub_flags;
  logic       clk;
  logic [7:0] a, b;
  logic       sub;
  logic [7:0] res;
  logic [5:0] flg;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  addsub_flags u0 (
    .a_in     (a),
    .b_in     (b),
    .sub_mode (sub),
    .result   (res),
    .flags    (flg)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // watchdog
  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9: run hung, actual cycles=%0d expected <150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [13:0] model(input int x, input int y, input bit s);
    int r, pc;
    logic [7:0] r8;
    logic c, p, h, z, sg, o;
    if (s) r = x - y; else r = x + y;
    r8 = r[7:0];
    c  = s ? (x < y) : (r > 255);
    pc = 0;
    for (int i = 0; i < 8; i++) pc += r8[i];
    p  = (pc % 2 == 0);
    h  = s ? ((x & 15) < (y & 15)) : (((x & 15) + (y & 15)) > 15);
    z  = (r8 == 0);
    sg = r8[7];
    begin
      int sx, sy, sr;
      sx = (x > 127) ? x - 256 : x;
      sy = (y > 127) ? y - 256 : y;
      sr = s ? sx - sy : sx + sy;
      o  = (sr > 127) || (sr < -128);
    end
    return {r8, o, sg, z, h, p, c};
  endfunction

  task automatic apply_check(input int x, input int y, input bit s, input string tag);
    logic [13:0] e;
    a = x[7:0]; b = y[7:0]; sub = s;
    #1;
    e = model(x, y, s);
    checks++;
    if (res !== e[13:6] || flg !== e[5:0]) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h sub=%0b: actual res=%02h flags=%06b expected res=%02h flags=%06b",
               tag, x[7:0], y[7:0], s, res, flg, e[13:6], e[5:0]);
    end
  endtask

  // R9: all-zero operands, outputs settle with no clock edge
  task automatic t_idle;
    apply_check(0, 0, 0, "R9/R6/R4 idle");
    apply_check(0, 0, 1, "R9/R3 idle sub");
  endtask

  // R8 overflow boundaries
  task automatic t_overflow;
    apply_check(8'h7F, 8'h01, 0, "R8 add pos overflow");
    apply_check(8'h80, 8'h80, 0, "R8/R3/R6 add neg overflow");
    apply_check(8'h80, 8'h01, 1, "R8 sub overflow");
    apply_check(8'h7F, 8'hFF, 1, "R8 sub overflow pos");
  endtask

  // R3/R5 borrow and half-carry
  task automatic t_borrow;
    apply_check(8'h00, 8'h01, 1, "R3/R5 borrow");
    apply_check(8'h10, 8'h01, 1, "R5 nibble borrow");
    apply_check(8'h0F, 8'h01, 0, "R5 half carry");
    apply_check(8'hFF, 8'h01, 0, "R3/R6 carry wrap");
  endtask

  // R6/R7 zero and sign on equal operands
  task automatic t_equal;
    apply_check(8'h5A, 8'h5A, 1, "R6 equal sub");
    apply_check(8'h00, 8'h80, 0, "R7 sign");
  endtask

  // R1 exhaustive addition
  task automatic t_sweep_add;
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        apply_check(x, y, 0, "R1 sweep add");
  endtask

  // R2 exhaustive subtraction
  task automatic t_sweep_sub;
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        apply_check(x, y, 1, "R2 sweep sub");
  endtask

  initial begin
    a = 0; b = 0; sub = 0;
    @(negedge clk);
    t_idle();
    t_overflow();
    t_borrow();
    t_equal();
    t_sweep_add();
    t_sweep_sub();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule